// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This unit sits on the processor side of the interrupt path. An interrupt controller has already arbitrated among its sources and presents one request with a priority level and an event code. The sequencer takes the request only between instructions. It then latches the event code, saves the status word and the program counter into shadow registers, sets the block, privileged-mode and register-bank control bits, and sends fetch to a handler entry point. That entry point sits at a fixed offset of 0x600 above the vector base.

All entry effects are registered. They appear together one clock after the boundary strobe, and the fetch redirect pulse lasts exactly one cycle. The jump is immediate, not a delayed branch. Acceptance is refused while the block bit is set, and a refused request stays with the controller. A separate return strobe puts the saved status and program counter back in one cycle and also raises the redirect.

Top module: `intEntrySeq`

## Requirements
- R1: An entry happens only when `insnBoundary` is high in the cycle the request is sampled. Without the boundary strobe, `redirect` stays low in the following cycle.
- R2: A request is accepted only if all of these hold: `irqReq` is high, the block bit `srIn[28]` is clear, `irqLevel` is strictly greater than the mask field `srIn[7:4]`, and `rteStrobe` is low.
- R3: On entry, `evtCode` and `evtCode2` both take the value of `irqCode`.
- R4: On entry, `ssrOut` takes `srIn` and `spcOut` takes `pcIn`.
- R5: On entry, `srNew` equals `srIn` with bits 28 (block), 29 (register bank) and 30 (privileged mode) set to 1. All other bits, including the mask field `[7:4]`, are unchanged.
- R6: On entry, `pcNew` equals `vbrIn + 0x600`, and `redirect` is high in the cycle right after the sampling edge.
- R7: `redirect` is high for exactly one cycle per entry. No request is accepted in a cycle where `redirect` is already high.
- R8: A cycle with `rteStrobe` high sets `srNew` to `ssrOut` and `pcNew` to `spcOut` and raises `redirect`. It takes priority over a request in the same cycle.
- R9: A refused request leaves `evtCode`, `evtCode2`, `ssrOut` and `spcOut` unchanged.
- R10: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 1 | Request from the interrupt controller |
| irqLevel | input | 4 | Priority level of the request |
| irqCode | input | 12 | Event code of the request |
| insnBoundary | input | 1 | High at a break between instructions |
| rteStrobe | input | 1 | Return-from-exception restore strobe |
| srIn | input | 32 | Current status register |
| pcIn | input | 32 | Current program counter |
| vbrIn | input | 32 | Vector base register |
| srNew | output | 32 | Status register value to write back |
| pcNew | output | 32 | Fetch target |
| ssrOut | output | 32 | Saved status register |
| spcOut | output | 32 | Saved program counter |
| evtCode | output | 12 | First event register |
| evtCode2 | output | 12 | Second event register |
| redirect | output | 1 | One-cycle fetch redirect pulse |

## Verification
The bench sweeps every pairing of request level and mask value, with the block bit both set and clear and the boundary strobe both high and low. It checks the strict level-over-mask comparison at equal values: a design that used greater-or-equal would take an entry when the level equals the mask. The bench also checks that the mask field survives entry, which catches a design that overwrites it with the request level. It holds a request across two cycles to show that no second entry follows, where a design without the in-flight block would redirect twice. Finally, it fires a return strobe together with a live request and expects the restore to win rather than a fresh entry that would overwrite the shadow registers.

// File: rtl/intEntryPkg.sv
package intEntryPkg;
  typedef struct packed {
    logic takeEntry;
    logic doRestore;
  } seqStrobes_t;
endpackage

// File: rtl/intEntryCtrl.sv
module intEntryCtrl
  import intEntryPkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             irqReq,
  input  logic [LVL_W-1:0] irqLevel,
  input  logic             insnBoundary,
  input  logic             rteStrobe,
  input  logic             blockBit,
  input  logic [LVL_W-1:0] curMask,
  output seqStrobes_t      strobes,
  output logic             redirect
);
  logic redirectQ;
  logic levelWins;

  assign levelWins = irqLevel > curMask;

  always_comb begin
    strobes.doRestore = rteStrobe;
    strobes.takeEntry = irqReq && insnBoundary && !rteStrobe && !blockBit
                        && !redirectQ && levelWins;
  end

  always_ff @(posedge clk) begin
    if (!rstN) redirectQ <= 1'b0;
    else       redirectQ <= strobes.takeEntry || strobes.doRestore;
  end

  assign redirect = redirectQ;
endmodule

// File: rtl/intEntryPath.sv
module intEntryPath
  import intEntryPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EVT_W  = 12,
  parameter int BL_BIT = 28,
  parameter int RB_BIT = 29,
  parameter int MD_BIT = 30,
  parameter logic [DATA_W-1:0] HANDLER_OFS = 'h600
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [EVT_W-1:0]  irqCode,
  input  logic [DATA_W-1:0] srIn,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0] vbrIn,
  output logic [DATA_W-1:0] srNew,
  output logic [DATA_W-1:0] pcNew,
  output logic [DATA_W-1:0] ssrOut,
  output logic [DATA_W-1:0] spcOut,
  output logic [EVT_W-1:0]  evtCode,
  output logic [EVT_W-1:0]  evtCode2
);
  localparam logic [DATA_W-1:0] ONE = 1;
  localparam logic [DATA_W-1:0] FORCE_MASK =
    (ONE << BL_BIT) | (ONE << RB_BIT) | (ONE << MD_BIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srNew    <= '0;
      pcNew    <= '0;
      ssrOut   <= '0;
      spcOut   <= '0;
      evtCode  <= '0;
      evtCode2 <= '0;
    end else if (strobes.doRestore) begin
      srNew <= ssrOut;
      pcNew <= spcOut;
    end else if (strobes.takeEntry) begin
      evtCode  <= irqCode;
      evtCode2 <= irqCode;
      ssrOut   <= srIn;
      spcOut   <= pcIn;
      srNew    <= srIn | FORCE_MASK;
      pcNew    <= vbrIn + HANDLER_OFS;
    end
  end
endmodule

// File: rtl/intEntrySeq.sv
module intEntrySeq
  import intEntryPkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int LVL_W    = 4,
  parameter int EVT_W    = 12,
  parameter int BL_BIT   = 28,
  parameter int RB_BIT   = 29,
  parameter int MD_BIT   = 30,
  parameter int MASK_LSB = 4,
  parameter logic [DATA_W-1:0] HANDLER_OFS = 'h600
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqReq,
  input  logic [LVL_W-1:0]  irqLevel,
  input  logic [EVT_W-1:0]  irqCode,
  input  logic              insnBoundary,
  input  logic              rteStrobe,
  input  logic [DATA_W-1:0] srIn,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0] vbrIn,
  output logic [DATA_W-1:0] srNew,
  output logic [DATA_W-1:0] pcNew,
  output logic [DATA_W-1:0] ssrOut,
  output logic [DATA_W-1:0] spcOut,
  output logic [EVT_W-1:0]  evtCode,
  output logic [EVT_W-1:0]  evtCode2,
  output logic              redirect
);
  seqStrobes_t strobes;

  intEntryCtrl #(.LVL_W(LVL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqLevel(irqLevel),
    .insnBoundary(insnBoundary), .rteStrobe(rteStrobe),
    .blockBit(srIn[BL_BIT]), .curMask(srIn[MASK_LSB +: LVL_W]),
    .strobes(strobes), .redirect(redirect)
  );

  intEntryPath #(
    .DATA_W(DATA_W), .EVT_W(EVT_W), .BL_BIT(BL_BIT), .RB_BIT(RB_BIT),
    .MD_BIT(MD_BIT), .HANDLER_OFS(HANDLER_OFS)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .irqCode(irqCode),
    .srIn(srIn), .pcIn(pcIn), .vbrIn(vbrIn), .srNew(srNew), .pcNew(pcNew),
    .ssrOut(ssrOut), .spcOut(spcOut), .evtCode(evtCode), .evtCode2(evtCode2)
  );
endmodule

// File: rtl/intEntryChecker.sv
module intEntryChecker #(
  parameter int DATA_W   = 32,
  parameter int EVT_W    = 12,
  parameter int BL_BIT   = 28,
  parameter int RB_BIT   = 29,
  parameter int MD_BIT   = 30,
  parameter int MASK_LSB = 4,
  parameter int LVL_W    = 4,
  parameter logic [DATA_W-1:0] HANDLER_OFS = 'h600
) (
  input logic              clk,
  input logic              rstN,
  input logic              insnBoundary,
  input logic              rteStrobe,
  input logic [EVT_W-1:0]  irqCode,
  input logic [DATA_W-1:0] srIn,
  input logic [DATA_W-1:0] pcIn,
  input logic [DATA_W-1:0] vbrIn,
  input logic [DATA_W-1:0] srNew,
  input logic [DATA_W-1:0] pcNew,
  input logic [DATA_W-1:0] spcOut,
  input logic [EVT_W-1:0]  evtCode,
  input logic              redirect
);
  AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (!insnBoundary && !rteStrobe) |=> !redirect); // R1
  AST_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (srIn[BL_BIT] && !rteStrobe) |=> !redirect); // R2
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (redirect && !rteStrobe) |=> !redirect); // R7
  AST_EVT_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (redirect && !$past(rteStrobe)) |-> evtCode == $past(irqCode)); // R3
  AST_SAVED_PC: assert property (@(posedge clk) disable iff (!rstN)
    (redirect && !$past(rteStrobe)) |-> spcOut == $past(pcIn)); // R4
  AST_MASK_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (redirect && !$past(rteStrobe)) |->
      srNew[MASK_LSB +: LVL_W] == $past(srIn[MASK_LSB +: LVL_W])); // R5
  AST_CTRL_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (redirect && !$past(rteStrobe)) |->
      (srNew[BL_BIT] && srNew[RB_BIT] && srNew[MD_BIT])); // R5
  AST_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (redirect && !$past(rteStrobe)) |-> pcNew == $past(vbrIn) + HANDLER_OFS); // R6
  AST_RESTORE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rteStrobe |=> redirect); // R8
endmodule

bind intEntrySeq intEntryChecker #(
  .DATA_W(DATA_W), .EVT_W(EVT_W), .BL_BIT(BL_BIT), .RB_BIT(RB_BIT),
  .MD_BIT(MD_BIT), .MASK_LSB(MASK_LSB), .LVL_W(LVL_W), .HANDLER_OFS(HANDLER_OFS)
) uChk (
  .clk(clk), .rstN(rstN), .insnBoundary(insnBoundary), .rteStrobe(rteStrobe),
  .irqCode(irqCode), .srIn(srIn), .pcIn(pcIn), .vbrIn(vbrIn), .srNew(srNew),
  .pcNew(pcNew), .spcOut(spcOut), .evtCode(evtCode), .redirect(redirect)
);

// File: tb/tb_intEntrySeq.sv
`timescale 1ns/1ps
module tb_intEntrySeq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irqReq = 1'b0;
  logic [3:0]  irqLevel = '0;
  logic [11:0] irqCode = '0;
  logic        insnBoundary = 1'b0;
  logic        rteStrobe = 1'b0;
  logic [31:0] srIn = '0, pcIn = '0, vbrIn = '0;
  logic [31:0] srNew, pcNew, ssrOut, spcOut;
  logic [11:0] evtCode, evtCode2;
  logic        redirect;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] FORCE = 32'h7000_0000;

  logic [31:0] expSsr = '0, expSpc = '0;
  logic [11:0] expEvt = '0;

  always #4 clk = ~clk;

  intEntrySeq dut (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqLevel(irqLevel),
    .irqCode(irqCode), .insnBoundary(insnBoundary), .rteStrobe(rteStrobe),
    .srIn(srIn), .pcIn(pcIn), .vbrIn(vbrIn), .srNew(srNew), .pcNew(pcNew),
    .ssrOut(ssrOut), .spcOut(spcOut), .evtCode(evtCode), .evtCode2(evtCode2),
    .redirect(redirect)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    irqReq = 1'b0; insnBoundary = 1'b0; rteStrobe = 1'b0;
  endtask

  initial begin
    #(8 * 50000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] sr, pc, vbr;
    logic [11:0] code;
    bit take;
    @(negedge clk);
    step(); step();
    // R10: reset state
    check(redirect == 1'b0, "R10 redirect", {31'd0, redirect}, 32'd0);
    check(srNew == 0 && pcNew == 0, "R10 srNew/pcNew", srNew | pcNew, 32'd0);
    check(ssrOut == 0 && spcOut == 0, "R10 shadows", ssrOut | spcOut, 32'd0);
    check(evtCode == 0 && evtCode2 == 0, "R10 events",
          {20'd0, evtCode | evtCode2}, 32'd0);
    rstN = 1'b1;
    step();

    for (int lvl = 0; lvl < 16; lvl++)
      for (int msk = 0; msk < 16; msk++)
        for (int bl = 0; bl < 2; bl++)
          for (int bnd = 0; bnd < 2; bnd++) begin
            sr = ((32'(lvl * 37 + msk * 11 + bl * 5)) * 32'h0101_0101) ^ 32'h3C5A_0000;
            sr = (sr & ~32'h1000_00F0) | (32'(msk) << 4) | (32'(bl) << 28);
            pc = 32'h0C00_0000 + 32'(lvl * 4096 + msk * 16 + bl * 4 + bnd * 2);
            vbr = 32'h8000_0000 + (32'(lvl) << 12) + (32'(msk) << 8);
            code = 12'h200 + 12'(lvl * 32 + msk);
            irqReq = 1'b1; insnBoundary = bnd[0]; irqLevel = 4'(lvl);
            irqCode = code; srIn = sr; pcIn = pc; vbrIn = vbr;
            step();
            take = bnd[0] && !bl[0] && (lvl > msk);
            if (take) begin
              expSsr = sr; expSpc = pc; expEvt = code;
              check(redirect == 1'b1, "R2 accept", {31'd0, redirect}, 32'd1);
              check(srNew == (sr | FORCE), "R5 srNew", srNew, sr | FORCE);
              check(pcNew == vbr + 32'h600, "R6 pcNew", pcNew, vbr + 32'h600);
              check(evtCode == code && evtCode2 == code, "R3 events",
                    {evtCode2, 8'd0, evtCode}, {code, 8'd0, code});
              check(ssrOut == sr, "R4 ssrOut", ssrOut, sr);
              check(spcOut == pc, "R4 spcOut", spcOut, pc);
            end else begin
              check(redirect == 1'b0, bnd ? "R2 refuse" : "R1 no boundary",
                    {31'd0, redirect}, 32'd0);
              check(evtCode == expEvt && evtCode2 == expEvt, "R9 events kept",
                    {20'd0, evtCode}, {20'd0, expEvt});
              check(ssrOut == expSsr && spcOut == expSpc, "R9 shadows kept",
                    ssrOut, expSsr);
            end
            idle();
            step();
            check(redirect == 1'b0, "R7 one-cycle pulse", {31'd0, redirect}, 32'd0);
          end

    // R7: request held two cycles with block bit clear; only one entry
    srIn = 32'h0000_0010; pcIn = 32'h1234_5678; vbrIn = 32'h4000_0000;
    irqReq = 1'b1; insnBoundary = 1'b1; irqLevel = 4'd9; irqCode = 12'hABC;
    step();
    check(redirect == 1'b1, "R7 first entry", {31'd0, redirect}, 32'd1);
    expSsr = 32'h0000_0010; expSpc = 32'h1234_5678; expEvt = 12'hABC;
    irqCode = 12'h111; pcIn = 32'h9999_0000;
    step();
    check(redirect == 1'b0, "R7 no back-to-back entry", {31'd0, redirect}, 32'd0);
    check(evtCode == 12'hABC, "R7 event kept", {20'd0, evtCode}, 32'hABC);
    idle();
    step();

    // R8: restore
    srIn = 32'h7000_00F0; pcIn = 32'h0000_0600; rteStrobe = 1'b1;
    step();
    check(redirect == 1'b1, "R8 restore pulse", {31'd0, redirect}, 32'd1);
    check(srNew == expSsr, "R8 srNew", srNew, expSsr);
    check(pcNew == expSpc, "R8 pcNew", pcNew, expSpc);
    idle();
    step();

    // R8: restore wins over a simultaneous request
    srIn = 32'h0000_0000; pcIn = 32'h5555_0000; vbrIn = 32'h2000_0000;
    irqReq = 1'b1; insnBoundary = 1'b1; irqLevel = 4'd15; irqCode = 12'h777;
    rteStrobe = 1'b1;
    step();
    check(srNew == expSsr && pcNew == expSpc, "R8 priority restore", pcNew, expSpc);
    check(evtCode == expEvt, "R8 no entry with restore", {20'd0, evtCode},
          {20'd0, expEvt});
    check(spcOut == expSpc, "R8 shadow untouched", spcOut, expSpc);
    idle();
    step();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule